// File: doc/BRIEF.md
# Tree-Instruction Next-Address Selector

This block picks the next instruction address for a three-level multiway branch. One instruction carries eight candidate target addresses. Seven decision nodes, arranged as a binary tree, each name one condition-code bit. The block walks the tree against the registered condition codes, enables exactly one leaf and drives that leaf's target. It also raises a flag when the chosen leaf holds a store. The flag lets the memory side start conflict handling early.

The selection logic is split into four identical slices. Each slice owns two leaves and keeps its own copy of the condition codes. A slice drives all zeros unless one of its leaves is taken, so the slice outputs can simply be ORed together. A pending interrupt overrides the tree: every slice goes quiet and a fixed vector address is driven instead. All selection is combinational from the registered codes, so the address is ready in the same cycle that the targets and the tree description are presented.

Top module: `tree_branch_select`

## Requirements
- R1: Every slice's condition-code copy clears to zero in reset. It loads `cc_in` at a rising clock edge when `cc_wr` is high and holds its value while `cc_wr` is low.
- R2: Node k (0..6) tests condition bit `cc[tree_sel[3k+2:3k]]`. When that bit is 0, the walk goes to node 2k+1 (or the left leaf). When it is 1, the walk goes to node 2k+2 (or the right leaf).
- R3: The leaf number is the three decisions read root first: the root decision is bit 2 and the last decision is bit 0. Leaf i's target sits at `targets[16i+15:16i]`, and its store bit is `store_mask[i]`.
- R4: Without an interrupt, `next_addr` equals the target of the taken leaf in the same cycle that the inputs present it. No clock edge is needed between inputs and output.
- R5: Without an interrupt, exactly one of the eight leaves is taken.
- R6: Without an interrupt, `store_hit` equals the store bit of the taken leaf.
- R7: While `irq` is high, `next_addr` equals `IRQ_VECTOR` (default 16'hFF00) and `store_hit` is 0, whatever the tree, codes and store mask are.
- R8: Codes written at a clock edge steer the selection only from that edge on. In the cycle where `cc_wr` is raised, the selection still uses the previous codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cc_wr | input | 1 | Load enable for the condition codes |
| cc_in | input | 8 | New condition-code value |
| tree_sel | input | 21 | Seven 3-bit bit-select fields, node k at bits 3k+2:3k |
| targets | input | 128 | Eight 16-bit target addresses, leaf i at bits 16i+15:16i |
| store_mask | input | 8 | Bit i set: leaf i holds a store |
| irq | input | 1 | Interrupt request, overrides the tree |
| next_addr | output | 16 | Selected next instruction address |
| store_hit | output | 1 | A store lies on the taken path |

## Verification
The interrupt override and the store-on-taken-path flag can fall in the same cycle: a tree whose taken leaf carries a store while `irq` is high. The bench sets this up with every store bit set and the interrupt asserted. It expects the vector address and a cleared store flag. It then drops `irq` in the following cycle and expects the flag and the leaf target to come back. A condition-code write landing in the same cycle as a selection is also provoked. That case is judged by checking the old leaf before the edge and the new leaf after it.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
    localparam int TREE_LEVELS = 3;
    localparam int TREE_NODES  = (1 << TREE_LEVELS) - 1;
    localparam int TREE_LEAVES = 1 << TREE_LEVELS;
    localparam int LEAVES_PER_SLICE = 2;
    localparam int NUM_SLICES  = TREE_LEAVES / LEAVES_PER_SLICE;

    // node reached at a given level on the way to a leaf
    function automatic int node_on_path(input int leaf, input int level);
        int node;
        node = 0;
        for (int l = 0; l < level; l++) begin
            node = 2 * node + 1 + ((leaf >> (TREE_LEVELS - 1 - l)) & 1);
        end
        return node;
    endfunction
endpackage

// File: rtl/tbs_path_match.sv
module tbs_path_match
    import tbs_pkg::*;
#(
    parameter int CC_W  = 8,
    parameter int SEL_W = 3,
    parameter int LEAF  = 0
) (
    input  logic [CC_W-1:0]             cc,
    input  logic [TREE_NODES*SEL_W-1:0] tree_sel,
    output logic                        match
);
    logic [TREE_LEVELS-1:0] step_ok;

    // one AND term per level; the slice ORs the gated results
    for (genvar lv = 0; lv < TREE_LEVELS; lv++) begin : g_level
        localparam int NODE = node_on_path(LEAF, lv);
        localparam bit DIR  = ((LEAF >> (TREE_LEVELS - 1 - lv)) & 1) != 0;
        logic [SEL_W-1:0] bit_idx;
        assign bit_idx     = tree_sel[NODE*SEL_W +: SEL_W];
        assign step_ok[lv] = (cc[bit_idx] == DIR);
    end

    assign match = &step_ok;
endmodule

// File: rtl/tbs_slice.sv
module tbs_slice
    import tbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CC_W   = 8,
    parameter int SEL_W  = 3,
    parameter int SLICE  = 0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cc_wr,
    input  logic [CC_W-1:0]                      cc_in,
    input  logic [TREE_NODES*SEL_W-1:0]          tree_sel,
    input  logic [LEAVES_PER_SLICE*ADDR_W-1:0]   pair_targets,
    input  logic [LEAVES_PER_SLICE-1:0]          pair_store,
    input  logic                                 irq,
    output logic [LEAVES_PER_SLICE-1:0]          leaf_hit,
    output logic [ADDR_W-1:0]                    slice_addr,
    output logic                                 slice_store
);
    typedef struct packed {
        logic [CC_W-1:0] cc;
    } slice_state_t;

    slice_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cc_wr) st_d.cc = cc_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar j = 0; j < LEAVES_PER_SLICE; j++) begin : g_leaf
        tbs_path_match #(
            .CC_W (CC_W),
            .SEL_W(SEL_W),
            .LEAF (SLICE * LEAVES_PER_SLICE + j)
        ) u_match (
            .cc      (st_q.cc),
            .tree_sel(tree_sel),
            .match   (leaf_hit[j])
        );
    end

    // zero unless a local leaf is taken, so an external OR merges slices
    always_comb begin
        slice_addr  = '0;
        slice_store = 1'b0;
        for (int j = 0; j < LEAVES_PER_SLICE; j++) begin
            if (leaf_hit[j] && !irq) begin
                slice_addr  = slice_addr | pair_targets[j*ADDR_W +: ADDR_W];
                slice_store = slice_store | pair_store[j];
            end
        end
    end

    // R1: write loads, no write holds
    assert_cc_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cc_wr |=> st_q.cc == $past(cc_in));
    assert_cc_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_wr |=> $stable(st_q.cc));
    // quiet slice contributes nothing to the OR
    assert_quiet_slice_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || leaf_hit == '0) |-> (slice_addr == '0 && !slice_store));
endmodule

// File: rtl/tbs_or_merge.sv
module tbs_or_merge #(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic [N*W-1:0] parts,
    output logic [W-1:0]   merged
);
    always_comb begin
        merged = '0;
        for (int i = 0; i < N; i++) merged = merged | parts[i*W +: W];
    end
endmodule

// File: rtl/tree_branch_select.sv
module tree_branch_select
    import tbs_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          CC_W       = 8,
    parameter logic [15:0] IRQ_VECTOR = 16'hFF00
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cc_wr,
    input  logic [CC_W-1:0]                     cc_in,
    input  logic [TREE_NODES*$clog2(CC_W)-1:0]  tree_sel,
    input  logic [TREE_LEAVES*ADDR_W-1:0]       targets,
    input  logic [TREE_LEAVES-1:0]              store_mask,
    input  logic                                irq,
    output logic [ADDR_W-1:0]                   next_addr,
    output logic                                store_hit
);
    localparam int SEL_W   = $clog2(CC_W);
    localparam int PAIR_W  = LEAVES_PER_SLICE * ADDR_W;
    localparam int SOURCES = NUM_SLICES + 1;

    logic [TREE_LEAVES-1:0]       leaf_hit;
    logic [SOURCES*ADDR_W-1:0]    addr_parts;
    logic [NUM_SLICES-1:0]        store_parts;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        tbs_slice #(
            .ADDR_W(ADDR_W),
            .CC_W  (CC_W),
            .SEL_W (SEL_W),
            .SLICE (s)
        ) u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .cc_wr       (cc_wr),
            .cc_in       (cc_in),
            .tree_sel    (tree_sel),
            .pair_targets(targets[s*PAIR_W +: PAIR_W]),
            .pair_store  (store_mask[s*LEAVES_PER_SLICE +: LEAVES_PER_SLICE]),
            .irq         (irq),
            .leaf_hit    (leaf_hit[s*LEAVES_PER_SLICE +: LEAVES_PER_SLICE]),
            .slice_addr  (addr_parts[s*ADDR_W +: ADDR_W]),
            .slice_store (store_parts[s])
        );
    end

    // interrupt source joins the same OR as the slices
    assign addr_parts[NUM_SLICES*ADDR_W +: ADDR_W] =
        irq ? IRQ_VECTOR[ADDR_W-1:0] : '0;

    tbs_or_merge #(.N(SOURCES), .W(ADDR_W)) u_addr_or (
        .parts (addr_parts),
        .merged(next_addr)
    );

    tbs_or_merge #(.N(NUM_SLICES), .W(1)) u_store_or (
        .parts (store_parts),
        .merged(store_hit)
    );

    // checking aid: target of whichever leaf is reported taken
    logic [ADDR_W-1:0] hit_target;
    always_comb begin
        hit_target = '0;
        for (int i = 0; i < TREE_LEAVES; i++)
            if (leaf_hit[i]) hit_target = targets[i*ADDR_W +: ADDR_W];
    end

    assert_one_leaf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(leaf_hit) == 1);
    assert_addr_follows_leaf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> next_addr == hit_target);
    assert_store_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> store_hit == |(leaf_hit & store_mask));
    assert_irq_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (next_addr == IRQ_VECTOR[ADDR_W-1:0] && !store_hit));
endmodule

// File: tb/tree_branch_select_test.sv
module tree_branch_select_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cc_wr = 1'b0;
    logic [7:0]   cc_in = '0;
    logic [20:0]  tree_sel = '0;
    logic [127:0] targets = '0;
    logic [7:0]   store_mask = '0;
    logic         irq = 1'b0;
    logic [15:0]  next_addr;
    logic         store_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] cc_model = '0;

    always #10 clk = ~clk;

    tree_branch_select uut (
        .clk(clk), .rst_n(rst_n), .cc_wr(cc_wr), .cc_in(cc_in),
        .tree_sel(tree_sel), .targets(targets), .store_mask(store_mask),
        .irq(irq), .next_addr(next_addr), .store_hit(store_hit)
    );

    function automatic int model_leaf(input logic [7:0] cc, input logic [20:0] sel);
        int node = 0;
        int leaf = 0;
        for (int lv = 0; lv < 3; lv++) begin
            int b = cc[sel[3*node +: 3]];
            leaf = (leaf << 1) | b;
            node = 2 * node + 1 + b;
        end
        return leaf;
    endfunction

    function automatic logic [15:0] tgt(input int leaf);
        return targets[16*leaf +: 16];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_sel(input string req);
        int l = model_leaf(cc_model, tree_sel);
        check(next_addr == tgt(l), {req, " addr"}, next_addr, tgt(l));
        check(store_hit == store_mask[l], {req, " store"}, store_hit, store_mask[l]);
    endtask

    task automatic write_cc(input logic [7:0] v);
        @(negedge clk);
        cc_in = v; cc_wr = 1'b1;
        @(negedge clk);
        cc_wr = 1'b0;
        cc_model = v;
        #2;
    endtask

    task automatic fill_targets();
        for (int i = 0; i < 8; i++) targets[16*i +: 16] = 16'h1000 * (i + 1) + 16'($urandom_range(0, 4095));
    endtask

    task automatic test_reset();
        fill_targets();
        tree_sel = 21'($urandom);
        store_mask = 8'hA5;
        #2;
        // R1: codes are zero after reset, so every node is false: leaf 0
        check(next_addr == tgt(0), "R1 reset addr", next_addr, tgt(0));
        check(store_hit == store_mask[0], "R1 reset store", store_hit, store_mask[0]);
    endtask

    task automatic test_each_leaf();
        // node k tests cc bit k (R2); walk each leaf by crafted codes (R3)
        for (int k = 0; k < 7; k++) tree_sel[3*k +: 3] = 3'(k);
        store_mask = 8'b0110_1001;
        for (int l = 0; l < 8; l++) begin
            logic [7:0] v;
            int b2 = (l >> 2) & 1, b1 = (l >> 1) & 1, b0 = l & 1;
            v = '0;
            v[0] = 1'(b2); v[1] = 1'(b1); v[2] = 1'(b1);
            for (int k = 3; k < 7; k++) v[k] = 1'(b0);
            write_cc(v);
            check(next_addr == tgt(l), "R2 R3 leaf addr", next_addr, tgt(l));
            check(store_hit == store_mask[l], "R6 leaf store", store_hit, store_mask[l]);
        end
    endtask

    task automatic test_random_tree();
        for (int n = 0; n < 40; n++) begin
            write_cc(8'($urandom));
            @(negedge clk);
            fill_targets();
            tree_sel = 21'($urandom);
            store_mask = 8'($urandom);
            #2;
            check_sel("R4 R5 random");
        end
    endtask

    task automatic test_cc_hold();
        write_cc(8'h5C);
        @(negedge clk);
        cc_in = 8'hA3; // no write enable: must be ignored
        @(negedge clk);
        @(negedge clk);
        #2;
        check_sel("R1 hold without write");
    endtask

    task automatic test_cc_timing();
        logic [7:0] nv;
        for (int k = 0; k < 7; k++) tree_sel[3*k +: 3] = 3'(k);
        write_cc(8'h00);
        nv = 8'h7F; // leaf 7 once loaded
        @(negedge clk);
        cc_in = nv; cc_wr = 1'b1;
        #2;
        check(next_addr == tgt(0), "R8 old codes before edge", next_addr, tgt(0));
        @(posedge clk);
        #2;
        cc_wr = 1'b0;
        check(next_addr == tgt(7), "R8 new codes after edge", next_addr, tgt(7));
        cc_model = nv;
    endtask

    task automatic test_irq_with_store();
        @(negedge clk);
        store_mask = 8'hFF;
        irq = 1'b1;
        #2;
        check(next_addr == 16'hFF00, "R7 vector", next_addr, 16'hFF00);
        check(store_hit == 1'b0, "R7 store suppressed", store_hit, 0);
        write_cc(8'($urandom));
        check(next_addr == 16'hFF00, "R7 vector after cc change", next_addr, 16'hFF00);
        @(negedge clk);
        irq = 1'b0;
        #2;
        check(store_hit == 1'b1, "R6 store returns", store_hit, 1);
        check_sel("R4 after irq");
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #35;
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_each_leaf();
        test_random_tree();
        test_cc_hold();
        test_cc_timing();
        test_irq_with_store();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule